// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps time for a processor core. It holds two 64-bit up-counters (a primary time base and an alternate time base) and one or two 32-bit down-counters (a decrementer and an optional second decrementer for hypervisor use). All counters move on a one-cycle `tick` strobe, which the surrounding clock logic produces at the time-base rate. Software reaches every counter through a small register port. Each time base is read and written as two independent 32-bit words. Each decrementer is read and written as one word.

The `tb_enable` input freezes both time bases together and lets them resume from the held values. The decrementers ignore it. A decrementer raises its interrupt request when it counts from zero to all-ones. It also raises the request at once when software writes a value with bit 31 set over a value with bit 31 clear. The request stays up until its acknowledge strobe. The `rate_change` strobe marks a new tick rate: it refills every decrementer with all-ones and withdraws any pending request. An optional compatibility window shows the primary low word through the mask 0x3FFFFF80.

Two small state machines govern the block:
- Freeze controller: states `TB_HALTED` and `TB_RUNNING`. It goes HALTED→RUNNING when `tb_enable` is sampled high, and RUNNING→HALTED when `tb_enable` is sampled low.
- Request machine, one per decrementer: states `IRQ_IDLE` and `IRQ_PENDING`.
  - IDLE→PENDING on an underflow or on a negative-over-non-negative write.
  - PENDING→IDLE on acknowledge, unless a new raise happens in the same cycle.
  - Any state→IDLE on `rate_change`.

Top module: `timebase_dec_unit`

## Requirements
- R1: After reset both time bases read 0, both decrementers read 0xFFFFFFFF and both requests are low. A `reg_rd` strobe returns the addressed word on `reg_rdata`, with `reg_rvalid` high, on the following cycle.
- R2: While running, each time base adds one per `tick`, and the low word carries into the high word.
- R3: A write to address 0 replaces only the primary low word, and a write to address 1 replaces only the primary high word.
- R4: The alternate time base (low word at address 2, high word at address 3) counts and is written independently of the primary one.
- R5: After `tb_enable` has been sampled low, both time bases hold their values through ticks. One cycle after `tb_enable` is sampled high again, they resume from the held values.
- R6: The decrementer (address 4) subtracts one per `tick` whatever the state of `tb_enable`.
- R7: A tick at decrementer value 0 loads 0xFFFFFFFF and sets `dec_irq`.
- R8: A raised request stays high until an acknowledge strobe, and it is low in the cycle after the acknowledge.
- R9: A write with bit 31 set over a current value whose bit 31 is clear sets the request in the next cycle. A write of a value with bit 31 set over a value with bit 31 already set does not.
- R10: In a cycle where a write and a tick target the same counter, the written value is stored and the tick is dropped for that counter.
- R11: A `rate_change` strobe loads 0xFFFFFFFF into every decrementer and clears their requests.
- R12: Address 6 is the compatibility view. A write there stores the written data ANDed with 0x3FFFFF80 into the primary low word, and a read there returns the primary low word ANDed with the same mask.
- R13: The second decrementer (address 5, `hdec_irq`, `hdec_ack`) behaves like the first and is independent of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base advance strobe |
| tb_enable | input | 1 | High lets both time bases count |
| rate_change | input | 1 | Strobe: refill decrementers, clear requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| dec_ack | input | 1 | Acknowledge for dec_irq |
| dec_irq | output | 1 | Decrementer interrupt request |
| hdec_ack | input | 1 | Acknowledge for hdec_irq |
| hdec_irq | output | 1 | Second decrementer interrupt request |

## Verification
The assertions assume that `reg_wr` addresses one word per cycle, so a low-word write and a high-word write never coincide. They also assume that `tb_enable` changes only between ticks when a resume is checked, and that acknowledges arrive only while a request may be pending. The stimulus writes one register per cycle and changes `tb_enable` only in a tick-free cycle that precedes any ticks it expects to count. Reads are issued only in cycles without a tick, so every expected word is fixed at the moment it is sampled.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_TB_LO  = 3'd0;
    localparam logic [REG_AW-1:0] A_TB_HI  = 3'd1;
    localparam logic [REG_AW-1:0] A_ATB_LO = 3'd2;
    localparam logic [REG_AW-1:0] A_ATB_HI = 3'd3;
    localparam logic [REG_AW-1:0] A_DEC    = 3'd4;
    localparam logic [REG_AW-1:0] A_HDEC   = 3'd5;
    localparam logic [REG_AW-1:0] A_RTC    = 3'd6;

    typedef enum logic {
        TB_HALTED,
        TB_RUNNING
    } tb_state_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PENDING
    } irq_state_e;
endpackage

// File: rtl/tbd_freeze_ctl.sv
module tbd_freeze_ctl
    import tbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic running
);
    tb_state_e state_q;
    tb_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_HALTED:  if (enable)  state_d = TB_RUNNING;
            TB_RUNNING: if (!enable) state_d = TB_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TB_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == TB_RUNNING);
    end

    // R5
    halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !running);

    // R5
    resume_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> running);
endmodule

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wdata,
    output logic [W-1:0]   value
);
    localparam int H = W / 2;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (wr_lo) begin
            val_q[H-1:0] <= wdata;
        end else if (wr_hi) begin
            val_q[W-1:H] <= wdata;
        end else if (advance) begin
            val_q <= val_q + ONE;
        end
    end

    assign value = val_q;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !wr_lo && !wr_hi) |=> $stable(value));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_lo && !wr_hi) |=> (value == $past(value) + ONE));

    // R3
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (value[W-1:H] == $past(value[W-1:H])));

    // R3
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (value[H-1:0] == $past(value[H-1:0])));
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer
    import tbd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack,
    output logic [W-1:0] count,
    output logic         irq
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    irq_state_e   st_q;
    irq_state_e   st_d;
    logic         underflow;
    logic         neg_write;
    logic         raise;

    assign underflow = tick && !wr && !reload && (cnt_q == '0);
    assign neg_write = wr && !reload && wdata[W-1] && !cnt_q[W-1];
    assign raise     = underflow || neg_write;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= ALL_ONES;
        else if (reload) cnt_q <= ALL_ONES;
        else if (wr)     cnt_q <= wdata;
        else if (tick)   cnt_q <= cnt_q - ONE;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE:    if (raise)         st_d = IRQ_PENDING;
            IRQ_PENDING: if (ack && !raise) st_d = IRQ_IDLE;
        endcase
        if (reload) st_d = IRQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        irq   = (st_q == IRQ_PENDING);
        count = cnt_q;
    end

    // R7
    underflow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && !reload && count == '0) |=> (count == ALL_ONES && irq));

    // R8
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !reload) |=> irq);

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && !tick && !wr && !reload) |=> !irq);

    // R9
    neg_write_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !reload && wdata[W-1] && !count[W-1]) |=> irq);

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !reload) |=> (count == $past(wdata)));

    // R11
    reload_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == ALL_ONES && !irq));
endmodule

// File: rtl/timebase_dec_unit.sv
module timebase_dec_unit
    import tbd_pkg::*;
#(
    parameter int          TB_W         = 64,
    parameter int          DEC_W        = 32,
    parameter bit          HAS_HDEC     = 1'b1,
    parameter bit          HAS_RTC_VIEW = 1'b1,
    parameter logic [31:0] RTC_MASK     = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tb_enable,
    input  logic              rate_change,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DEC_W-1:0]  reg_wdata,
    output logic [DEC_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic              dec_ack,
    output logic              dec_irq,
    input  logic              hdec_ack,
    output logic              hdec_irq
);
    localparam int N_TB = 2;
    localparam int HW   = TB_W / 2;
    localparam logic [HW-1:0] VIEW_MASK = HW'(RTC_MASK);

    logic             running;
    logic             advance;
    logic [N_TB-1:0]  tb_wr_lo;
    logic [N_TB-1:0]  tb_wr_hi;
    logic [HW-1:0]    tb_wdata [N_TB];
    logic [TB_W-1:0]  tb_val   [N_TB];
    logic             dec_wr;
    logic             hdec_wr;
    logic [DEC_W-1:0] dec_count;
    logic [DEC_W-1:0] hdec_count;
    logic [DEC_W-1:0] rd_mux;

    tbd_freeze_ctl u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tb_enable),
        .running (running)
    );

    assign advance = tick && running;

    // Write decode: one word per cycle.
    always_comb begin
        tb_wr_lo = '0;
        tb_wr_hi = '0;
        dec_wr   = 1'b0;
        hdec_wr  = 1'b0;
        for (int k = 0; k < N_TB; k++) tb_wdata[k] = reg_wdata;
        if (reg_wr) begin
            case (reg_addr)
                A_TB_LO:  tb_wr_lo[0] = 1'b1;
                A_TB_HI:  tb_wr_hi[0] = 1'b1;
                A_ATB_LO: tb_wr_lo[1] = 1'b1;
                A_ATB_HI: tb_wr_hi[1] = 1'b1;
                A_DEC:    dec_wr      = 1'b1;
                A_HDEC:   hdec_wr     = HAS_HDEC;
                A_RTC: begin
                    if (HAS_RTC_VIEW) begin
                        tb_wr_lo[0] = 1'b1;
                        tb_wdata[0] = reg_wdata & VIEW_MASK;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_TB; g++) begin : g_tb
        tbd_timebase #(.W(TB_W)) u_tb (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (advance),
            .wr_lo   (tb_wr_lo[g]),
            .wr_hi   (tb_wr_hi[g]),
            .wdata   (tb_wdata[g]),
            .value   (tb_val[g])
        );
    end

    tbd_decrementer #(.W(DEC_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (rate_change),
        .wr     (dec_wr),
        .wdata  (reg_wdata),
        .ack    (dec_ack),
        .count  (dec_count),
        .irq    (dec_irq)
    );

    if (HAS_HDEC) begin : g_hdec
        tbd_decrementer #(.W(DEC_W)) u_hdec (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .reload (rate_change),
            .wr     (hdec_wr),
            .wdata  (reg_wdata),
            .ack    (hdec_ack),
            .count  (hdec_count),
            .irq    (hdec_irq)
        );
    end else begin : g_no_hdec
        assign hdec_count = '0;
        assign hdec_irq   = 1'b0;
    end

    always_comb begin
        unique case (reg_addr)
            A_TB_LO:  rd_mux = tb_val[0][HW-1:0];
            A_TB_HI:  rd_mux = tb_val[0][TB_W-1:HW];
            A_ATB_LO: rd_mux = tb_val[1][HW-1:0];
            A_ATB_HI: rd_mux = tb_val[1][TB_W-1:HW];
            A_DEC:    rd_mux = dec_count;
            A_HDEC:   rd_mux = hdec_count;
            A_RTC:    rd_mux = HAS_RTC_VIEW ? (tb_val[0][HW-1:0] & VIEW_MASK) : '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    // R1
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R4
    alt_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_ATB_LO || reg_addr == A_ATB_HI) && !advance)
        |=> $stable(tb_val[0]));

    if (HAS_RTC_VIEW) begin : g_rtc_chk
        // R12
        rtc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_RTC) |=> ((tb_val[0][HW-1:0] & ~VIEW_MASK) == '0));
    end
endmodule

// File: tb/test_timebase_dec_unit.sv
`timescale 1ns/1ps
module test_timebase_dec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        tb_enable = 1'b1;
    logic        rate_change = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        dec_ack = 1'b0;
    logic        dec_irq;
    logic        hdec_ack = 1'b0;
    logic        hdec_irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    timebase_dec_unit i_timebase_dec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .tb_enable   (tb_enable),
        .rate_change (rate_change),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .reg_rvalid  (reg_rvalid),
        .dec_ack     (dec_ack),
        .dec_irq     (dec_irq),
        .hdec_ack    (hdec_ack),
        .hdec_irq    (hdec_irq)
    );

    // Monitor: pops the scoreboard whenever read data comes back.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid === 1'b1) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_rd = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic with_tick);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        tick = with_tick;
        @(negedge clk);
        reg_wr = 1'b0;
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(3'd0, 32'h0, "R1 tb lo");
        rd(3'd1, 32'h0, "R1 tb hi");
        rd(3'd2, 32'h0, "R1 atb lo");
        rd(3'd3, 32'h0, "R1 atb hi");
        rd(3'd4, 32'hFFFF_FFFF, "R1 dec");
        rd(3'd5, 32'hFFFF_FFFF, "R1 hdec");
        check_bit(dec_irq, 1'b0, "R1 dec_irq");
        check_bit(hdec_irq, 1'b0, "R1 hdec_irq");

        // R2 / R6 counting
        ticks(5);
        rd(3'd0, 32'd5, "R2 tb lo after 5");
        rd(3'd2, 32'd5, "R2 atb lo after 5");
        rd(3'd4, 32'hFFFF_FFFA, "R6 dec after 5");

        // R3 half writes, R2 carry
        wr(3'd0, 32'hFFFF_FFFE, 1'b0);
        wr(3'd1, 32'h0000_0007, 1'b0);
        rd(3'd1, 32'h7, "R3 hi written");
        rd(3'd0, 32'hFFFF_FFFE, "R3 lo kept by hi write");
        ticks(3);
        rd(3'd1, 32'h8, "R2 carry into hi");
        rd(3'd0, 32'h1, "R2 lo after carry");

        // R4 alternate independence
        wr(3'd3, 32'h1234_5678, 1'b0);
        rd(3'd3, 32'h1234_5678, "R4 atb hi");
        rd(3'd2, 32'h8, "R4 atb lo");
        rd(3'd1, 32'h8, "R4 tb hi untouched");

        // R5 freeze, R6 decrementer keeps counting
        tb_enable = 1'b0;
        idle(1);
        ticks(4);
        rd(3'd0, 32'h1, "R5 tb frozen");
        rd(3'd2, 32'h8, "R5 atb frozen");
        rd(3'd4, 32'hFFFF_FFF3, "R6 dec while frozen");
        tb_enable = 1'b1;
        idle(1);
        ticks(2);
        rd(3'd0, 32'h3, "R5 tb resumed");
        rd(3'd2, 32'hA, "R5 atb resumed");

        // R10 write wins over tick
        wr(3'd0, 32'h100, 1'b1);
        rd(3'd0, 32'h100, "R10 tb lo write vs tick");
        wr(3'd4, 32'h40, 1'b1);
        rd(3'd4, 32'h40, "R10 dec write vs tick");
        rd(3'd2, 32'hC, "R10 atb still ticked");

        // R7 underflow
        wr(3'd4, 32'h2, 1'b0);
        ticks(2);
        check_bit(dec_irq, 1'b0, "R7 no irq at zero");
        ticks(1);
        check_bit(dec_irq, 1'b1, "R7 irq on wrap");
        rd(3'd4, 32'hFFFF_FFFF, "R7 wrapped value");
        check_bit(hdec_irq, 1'b0, "R13 hdec unaffected");

        // R8 hold until acknowledge
        idle(3);
        check_bit(dec_irq, 1'b1, "R8 irq held");
        dec_ack = 1'b1;
        idle(1);
        dec_ack = 1'b0;
        check_bit(dec_irq, 1'b0, "R8 irq cleared by ack");

        // R9 negative write
        wr(3'd4, 32'h8000_0000, 1'b0);
        check_bit(dec_irq, 1'b0, "R9 neg over neg");
        wr(3'd4, 32'h5, 1'b0);
        check_bit(dec_irq, 1'b0, "R9 positive write");
        wr(3'd4, 32'h8000_0001, 1'b0);
        check_bit(dec_irq, 1'b1, "R9 neg over non-neg");
        rd(3'd4, 32'h8000_0001, "R9 dec value");
        dec_ack = 1'b1;
        idle(1);
        dec_ack = 1'b0;

        // R13 second decrementer
        wr(3'd5, 32'h1, 1'b0);
        ticks(2);
        check_bit(hdec_irq, 1'b1, "R13 hdec wrap irq");
        check_bit(dec_irq, 1'b0, "R13 dec quiet through 0x80000000");
        rd(3'd4, 32'h7FFF_FFFF, "R13 dec value");
        rd(3'd5, 32'hFFFF_FFFF, "R13 hdec value");
        hdec_ack = 1'b1;
        idle(1);
        hdec_ack = 1'b0;
        check_bit(hdec_irq, 1'b0, "R13 hdec ack");

        // R11 rate change
        wr(3'd4, 32'h0, 1'b0);
        ticks(1);
        check_bit(dec_irq, 1'b1, "R11 setup irq");
        wr(3'd4, 32'h1234, 1'b0);
        wr(3'd5, 32'h55, 1'b0);
        rate_change = 1'b1;
        idle(1);
        rate_change = 1'b0;
        check_bit(dec_irq, 1'b0, "R11 irq cleared");
        rd(3'd4, 32'hFFFF_FFFF, "R11 dec refilled");
        rd(3'd5, 32'hFFFF_FFFF, "R11 hdec refilled");

        // R12 compatibility view
        wr(3'd6, 32'hFFFF_FFFF, 1'b0);
        rd(3'd0, 32'h3FFF_FF80, "R12 masked write");
        rd(3'd1, 32'h8, "R12 hi untouched");
        wr(3'd0, 32'hFFFF_FFFF, 1'b0);
        rd(3'd6, 32'h3FFF_FF80, "R12 masked read");

        idle(3);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule